// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of an 8-bit asynchronous NAND flash bus and carries out one page program per request. A request gives a 32-bit target address and a byte count. After the block accepts it, the block sends the program setup command and the four address bytes. It then draws the write bytes from a valid/ready stream, writes each byte to the device, and sends the confirm command. While the device programs, the block sends no bus cycle at all.

When ready/busy rises, the block sends the status command and reads the status byte. It keeps reading until the status reports the controller ready. The status error bit then decides between pass and fail. A busy phase that lasts too long ends the operation with a timeout. A request with an illegal byte count is turned away before the bus does anything.

Every bus cycle holds its strobe low for a set number of clocks and high for another set number, both taken from configuration inputs. This lets one design meet the device's minimum pulse widths at any clock rate.

Top module: `nand_pgm_seq`

## Requirements
- R1: A request with req_len of 0 or greater than 528 gets no bus activity: nf_ce_n and nf_we_n stay high. The next cycle gives done with err_len set and pass low.
- R2: The first write cycle of an accepted request carries 0x80 with nf_cle high and nf_ale low.
- R3: Four write cycles follow with nf_ale high and nf_cle low. They carry req_addr bits [7:0], [15:8], [23:16] and [31:24], in that order.
- R4: Exactly req_len data write cycles follow, with nf_cle and nf_ale low. Each carries the next byte taken on the stream, in stream order. wr_ready is high only while the block waits for a data byte.
- R5: After the last data byte, one write cycle carries 0x10 with nf_cle high.
- R6: In every bus cycle the active strobe (nf_we_n or nf_re_n) stays low for max(cfg_lo,1) clocks and then high for max(cfg_hi,1) clocks. Only one of the two strobes is low at a time.
- R7: From the confirm cycle until nf_rdy is high again, neither strobe goes low.
- R8: Once nf_rdy is high, a write cycle carrying 0x70 with nf_cle high follows. Read cycles (nf_re_n low, nf_io_oe low) then repeat until a status byte has bit 6 set.
- R9: For the final status byte, bit 0 = 1 gives done with err_prog set and pass low. Bit 0 = 0 gives done with pass set.
- R10: If nf_rdy stays low for cfg_busy_limit clocks after the confirm cycle, the block gives done with err_tmo set and pass low, and sends no status command.
- R11: done lasts exactly one cycle, and exactly one of pass, err_prog, err_tmo and err_len is high with it. req_ready is high in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Four address bytes, least significant byte sent first |
| req_len | input | 10 | Number of bytes to program |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Write stream byte taken |
| cfg_lo | input | 4 | Strobe low clocks per bus cycle (0 means 1) |
| cfg_hi | input | 4 | Strobe high clocks per bus cycle (0 means 1) |
| cfg_busy_limit | input | 16 | Busy timeout in clocks |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | I/O bus value driven by the block |
| nf_io_oe | output | 1 | I/O bus output enable |
| nf_io_in | input | 8 | I/O bus value from the device |
| nf_rdy | input | 1 | Device ready/busy, low while busy |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Program succeeded, valid with done |
| err_prog | output | 1 | Device reported program failure, valid with done |
| err_tmo | output | 1 | Busy timeout, valid with done |
| err_len | output | 1 | Request rejected for its byte count, valid with done |

## Verification
The assertions check on every cycle that the block stays silent while the device is busy. They also check that no two strobes are low together and that the bus byte holds steady through a write strobe. They check that the done pulse lasts a single cycle, carries exactly one verdict and is followed by idle, and that a bad byte count is answered at once. Only the bench scenarios can show the rest. That covers the exact byte order of command, address, data and confirm cycles against the stream, the measured strobe widths for several settings, the repeated status reads before the ready bit appears, the 528-byte boundary, and the timeout path.

// File: rtl/nand_pgm_pkg.sv
package nand_pgm_pkg;
  localparam logic [7:0] OP_SETUP  = 8'h80;
  localparam logic [7:0] OP_GO     = 8'h10;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam int unsigned ST_RDY_BIT  = 6;
  localparam int unsigned ST_FAIL_BIT = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADDR, S_DATA, S_GO, S_BUSY, S_STCMD, S_STRD, S_REPORT
  } seq_state_e;

  typedef struct packed {
    logic ok;
    logic prog_fail;
    logic timeout;
    logic bad_len;
  } seq_result_t;
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_rd,
  input  logic          start_cle,
  input  logic          start_ale,
  input  logic [7:0]    start_byte,
  input  logic [TW-1:0] lo_cyc,
  input  logic [TW-1:0] hi_cyc,
  input  logic [7:0]    io_in,
  output logic          idle,
  output logic          fin,
  output logic          we_n,
  output logic          re_n,
  output logic          cle,
  output logic          ale,
  output logic [7:0]    io_out,
  output logic          io_oe,
  output logic [7:0]    rd_byte
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic          act_q, act_d, hi_q, hi_d, rd_q, rd_d, cle_q, cle_d, ale_q, ale_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [7:0]    byte_q, byte_d, rdb_q, rdb_d;
  logic [TW-1:0] lo_lim, hi_lim;
  logic          last_lo, last_hi;

  assign lo_lim  = (lo_cyc == '0) ? ONE : lo_cyc;
  assign hi_lim  = (hi_cyc == '0) ? ONE : hi_cyc;
  assign last_lo = act_q && !hi_q && (cnt_q == lo_lim - ONE);
  assign last_hi = act_q &&  hi_q && (cnt_q == hi_lim - ONE);

  always_comb begin
    act_d  = act_q;
    hi_d   = hi_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    cle_d  = cle_q;
    ale_d  = ale_q;
    byte_d = byte_q;
    rdb_d  = rdb_q;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        hi_d   = 1'b0;
        cnt_d  = '0;
        rd_d   = start_rd;
        cle_d  = start_cle;
        ale_d  = start_ale;
        byte_d = start_byte;
      end
    end else if (!hi_q) begin
      if (last_lo) begin
        hi_d  = 1'b1;
        cnt_d = '0;
        if (rd_q) rdb_d = io_in;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (last_hi) begin
        act_d = 1'b0;
        hi_d  = 1'b0;
        cnt_d = '0;
        cle_d = 1'b0;
        ale_d = 1'b0;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hi_q   <= 1'b0;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      byte_q <= '0;
      rdb_q  <= '0;
    end else begin
      act_q  <= act_d;
      hi_q   <= hi_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
      cle_q  <= cle_d;
      ale_q  <= ale_d;
      byte_q <= byte_d;
      rdb_q  <= rdb_d;
    end
  end

  assign idle    = !act_q;
  assign fin     = last_hi;
  assign we_n    = !(act_q && !hi_q && !rd_q);
  assign re_n    = !(act_q && !hi_q &&  rd_q);
  assign cle     = act_q && cle_q;
  assign ale     = act_q && ale_q;
  assign io_out  = byte_q;
  assign io_oe   = act_q && !rd_q;
  assign rd_byte = rdb_q;

  // R6: a single strobe is active at any time
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R6: the written byte holds while the write strobe is low
  p_io_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(io_out));
  // R6: the strobe low phase never outlasts its configured width
  p_lo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !hi_q) |-> (cnt_q < lo_lim));
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                cnt_d = '0;
    else if (cnt_q != '1)   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign expired = en && (cnt_q >= limit);

  // R10: the timer restarts from zero for every busy phase
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (cnt_q == '0));
endmodule

// File: rtl/nand_pgm_seq.sv
module nand_pgm_seq
  import nand_pgm_pkg::*;
#(
  parameter int LEN_W     = 10,
  parameter int MAX_BYTES = 528,
  parameter int TW        = 4,
  parameter int CW        = 16,
  parameter int WB_CYC    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [TW-1:0]    cfg_lo,
  input  logic [TW-1:0]    cfg_hi,
  input  logic [CW-1:0]    cfg_busy_limit,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_io_out,
  output logic             nf_io_oe,
  input  logic [7:0]       nf_io_in,
  input  logic             nf_rdy,
  output logic             done,
  output logic             pass,
  output logic             err_prog,
  output logic             err_tmo,
  output logic             err_len
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);
  localparam logic [CW-1:0]    WB_MIN  = CW'(WB_CYC);

  seq_state_e        st_q, st_d;
  logic [1:0]        aidx_q, aidx_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [31:0]       addr_q, addr_d;
  seq_result_t       res_q, res_d;

  logic       eng_start, eng_rd, eng_cle, eng_ale, eng_idle, eng_fin;
  logic [7:0] eng_byte, eng_rdb;
  logic [CW-1:0] bcnt;
  logic       b_exp, len_bad;

  assign len_bad = (req_len == '0) || (req_len > LEN_MAX);

  always_comb begin
    eng_start = 1'b0;
    eng_rd    = 1'b0;
    eng_cle   = 1'b0;
    eng_ale   = 1'b0;
    eng_byte  = '0;
    unique case (st_q)
      S_SETUP: begin eng_start = eng_idle; eng_cle = 1'b1; eng_byte = OP_SETUP; end
      S_ADDR:  begin eng_start = eng_idle; eng_ale = 1'b1; eng_byte = addr_q[8*aidx_q +: 8]; end
      S_DATA:  begin eng_start = eng_idle && wr_valid; eng_byte = wr_data; end
      S_GO:    begin eng_start = eng_idle; eng_cle = 1'b1; eng_byte = OP_GO; end
      S_STCMD: begin eng_start = eng_idle; eng_cle = 1'b1; eng_byte = OP_STATUS; end
      S_STRD:  begin eng_start = eng_idle; eng_rd  = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    aidx_d = aidx_q;
    left_d = left_q;
    addr_d = addr_q;
    res_d  = res_q;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        res_d = '0;
        if (len_bad) begin
          res_d.bad_len = 1'b1;
          st_d = S_REPORT;
        end else begin
          addr_d = req_addr;
          left_d = req_len;
          aidx_d = '0;
          st_d   = S_SETUP;
        end
      end
      S_SETUP: if (eng_fin) st_d = S_ADDR;
      S_ADDR: if (eng_fin) begin
        aidx_d = aidx_q + 2'd1;
        if (aidx_q == 2'd3) st_d = S_DATA;
      end
      S_DATA: if (eng_fin) begin
        left_d = left_q - LEN_W'(1);
        if (left_q == LEN_W'(1)) st_d = S_GO;
      end
      S_GO: if (eng_fin) st_d = S_BUSY;
      S_BUSY: begin
        if (nf_rdy && (bcnt >= WB_MIN)) st_d = S_STCMD;
        else if (b_exp) begin
          res_d.timeout = 1'b1;
          st_d = S_REPORT;
        end
      end
      S_STCMD: if (eng_fin) st_d = S_STRD;
      S_STRD: if (eng_fin && eng_rdb[ST_RDY_BIT]) begin
        res_d.prog_fail = eng_rdb[ST_FAIL_BIT];
        res_d.ok        = !eng_rdb[ST_FAIL_BIT];
        st_d = S_REPORT;
      end
      S_REPORT: st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      aidx_q <= '0;
      left_q <= '0;
      addr_q <= '0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      aidx_q <= aidx_d;
      left_q <= left_d;
      addr_q <= addr_d;
      res_q  <= res_d;
    end
  end

  nand_bus_cycle #(.TW(TW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .start_rd(eng_rd),
    .start_cle(eng_cle), .start_ale(eng_ale), .start_byte(eng_byte),
    .lo_cyc(cfg_lo), .hi_cyc(cfg_hi), .io_in(nf_io_in),
    .idle(eng_idle), .fin(eng_fin), .we_n(nf_we_n), .re_n(nf_re_n),
    .cle(nf_cle), .ale(nf_ale), .io_out(nf_io_out), .io_oe(nf_io_oe),
    .rd_byte(eng_rdb)
  );

  nand_busy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(st_q == S_BUSY), .limit(cfg_busy_limit),
    .count(bcnt), .expired(b_exp)
  );

  assign req_ready = (st_q == S_IDLE);
  assign wr_ready  = (st_q == S_DATA) && eng_idle;
  assign nf_ce_n   = (st_q == S_IDLE) || (st_q == S_REPORT);
  assign done      = (st_q == S_REPORT);
  assign pass      = done && res_q.ok;
  assign err_prog  = done && res_q.prog_fail;
  assign err_tmo   = done && res_q.timeout;
  assign err_len   = done && res_q.bad_len;

  // R1: an illegal count is answered at once with no strobe
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && len_bad) |=> (done && err_len && nf_we_n && nf_ce_n));
  // R4: stream bytes are only taken with both latch enables low
  p_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!nf_cle && !nf_ale && !nf_ce_n));
  // R7: silence on the bus while the device is busy
  p_quiet_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BUSY) |-> (nf_we_n && nf_re_n));
  // R11: one-cycle done followed by idle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  // R11: exactly one verdict with done
  p_one_verdict_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({pass, err_prog, err_tmo, err_len}) == 1));
endmodule

// File: tb/sim_nand_pgm_seq.sv
module sim_nand_pgm_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [9:0]  req_len = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [3:0]  cfg_lo = 4'd1, cfg_hi = 4'd1;
  logic [15:0] cfg_busy_limit = 16'd1000;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
  logic [7:0]  nf_io_out, nf_io_in;
  logic        nf_rdy = 1'b1;
  logic        done, pass, err_prog, err_tmo, err_len;

  nand_pgm_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_busy_limit(cfg_busy_limit),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
    .nf_rdy(nf_rdy), .done(done), .pass(pass), .err_prog(err_prog),
    .err_tmo(err_tmo), .err_len(err_len)
  );

  int total = 0, bad = 0;
  logic [9:0] exp_bus[$];
  int         exp_tag[$];
  logic [3:0] exp_res[$];

  // device model and source settings
  int   busy_len = 20;
  bit   hang = 0;
  int   busy_left = 0;
  int   nr_reads = 0;
  logic [7:0] fin_status = 8'h40;
  int   rd_count = 0;
  int   we_rises = 0;
  int   ce_lows = 0;
  int   res_seen = 0;
  int   src_len = 0, src_idx = 0;
  logic [7:0] src_seed = 0;
  bit   src_gap = 0, src_on = 0, hs_pend = 0;
  int   cyc = 0;

  assign nf_io_in = (rd_count < nr_reads) ? 8'h00 : fin_status;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // write-stream source
  always @(negedge clk) begin
    cyc++;
    if (hs_pend) src_idx++;
    wr_valid = src_on && (src_idx < src_len) && (!src_gap || cyc[0]);
    wr_data  = src_seed + 8'(src_idx * 13);
    hs_pend  = wr_valid && wr_ready;
  end

  // bus monitor and scoreboard
  logic prev_we = 1'b1, prev_re = 1'b1, prev_done = 1'b0, need_ready = 1'b0;
  logic [9:0] low_val;
  int lo_seen = 0, rlo_seen = 0;
  always @(negedge clk) begin
    if (!nf_ce_n) ce_lows++;
    if (busy_left > 0) begin
      busy_left--;
      if (busy_left == 0 && !hang) nf_rdy = 1'b1;
    end
    if (!nf_we_n) begin
      low_val = {nf_cle, nf_ale, nf_io_out};
      lo_seen++;
    end
    if (!nf_re_n) rlo_seen++;
    if (nf_we_n && !prev_we) begin
      we_rises++;
      // R7: nothing written while ready/busy is low
      chk(nf_rdy, "R7", "write while busy", 0, 1);
      // R6: strobe low width
      chk(lo_seen == ((cfg_lo == 0) ? 1 : cfg_lo), "R6", "we low width", lo_seen, cfg_lo);
      if (exp_bus.size() == 0) begin
        chk(0, "R7", "unexpected bus cycle", int'(low_val), 0);
      end else begin
        automatic logic [9:0] e = exp_bus.pop_front();
        automatic int t = exp_tag.pop_front();
        chk(low_val == e, $sformatf("R%0d", t), "bus cycle", int'(low_val), int'(e));
      end
      if (low_val == {2'b10, 8'h10}) begin
        nf_rdy = 1'b0;
        busy_left = busy_len;
      end
      lo_seen = 0;
    end
    if (nf_re_n && !prev_re) begin
      rd_count++;
      chk(rlo_seen == ((cfg_lo == 0) ? 1 : cfg_lo), "R6", "re low width", rlo_seen, cfg_lo);
      rlo_seen = 0;
    end
    if (need_ready) begin
      chk(req_ready && !done, "R11", "idle after done", int'(req_ready), 1);
      need_ready = 1'b0;
    end
    if (done) begin
      res_seen++;
      chk(!prev_done, "R11", "done longer than one cycle", 1, 0);
      if (exp_res.size() == 0) chk(0, "R11", "unexpected done", 1, 0);
      else begin
        automatic logic [3:0] e = exp_res.pop_front();
        automatic logic [3:0] a = {pass, err_prog, err_tmo, err_len};
        chk(a == e, "R9", "verdict {pass,prog,tmo,len}", int'(a), int'(e));
      end
      need_ready = 1'b1;
    end
    prev_we = nf_we_n;
    prev_re = nf_re_n;
    prev_done = done;
  end

  task automatic push_bus(logic c, logic a, logic [7:0] b, int tag);
    exp_bus.push_back({c, a, b});
    exp_tag.push_back(tag);
  endtask

  task automatic run_prog(logic [31:0] addr, int len, logic [3:0] lo, logic [3:0] hi,
                          int nrd, logic [7:0] fst, bit gap, bit hng, int blen);
    automatic bit badlen = (len == 0) || (len > 528);
    automatic int seen0 = res_seen;
    automatic int we0 = we_rises;
    automatic int ce0 = ce_lows;
    @(negedge clk);
    cfg_lo = lo; cfg_hi = hi;
    nr_reads = nrd; fin_status = fst; rd_count = 0;
    hang = hng; busy_len = blen;
    src_len = len; src_idx = 0; src_seed = addr[7:0] ^ 8'h5A; src_gap = gap;
    if (badlen) exp_res.push_back(4'b0001);
    else begin
      push_bus(1'b1, 1'b0, 8'h80, 2);
      for (int i = 0; i < 4; i++) push_bus(1'b0, 1'b1, addr[8*i +: 8], 3);
      for (int i = 0; i < len; i++) push_bus(1'b0, 1'b0, src_seed + 8'(i * 13), 4);
      push_bus(1'b1, 1'b0, 8'h10, 5);
      if (hng) exp_res.push_back(4'b0010);
      else begin
        push_bus(1'b1, 1'b0, 8'h70, 8);
        exp_res.push_back(fst[0] ? 4'b0100 : 4'b1000);
      end
    end
    src_on = 1;
    while (!req_ready) @(negedge clk);
    req_addr = addr; req_len = 10'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (res_seen == seen0) @(negedge clk);
    @(negedge clk);
    src_on = 0;
    if (badlen) begin
      chk(we_rises == we0 && ce_lows == ce0, "R1", "bus touched on reject", we_rises - we0, 0);
    end else begin
      chk(exp_bus.size() == 0, "R4", "missing bus cycles", exp_bus.size(), 0);
      chk(src_idx == len, "R4", "bytes taken from stream", src_idx, len);
      if (hng) chk(rd_count == 0, "R10", "status read after timeout", rd_count, 0);
      else     chk(rd_count == nrd + 1, "R8", "status reads", rd_count, nrd + 1);
    end
    exp_bus.delete(); exp_tag.delete();
    hang = 0; nf_rdy = 1'b1; busy_left = 0;
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    chk(!done && nf_we_n && nf_re_n && nf_ce_n && req_ready && !wr_ready,
        "R11", "reset state", int'({done, nf_we_n, nf_ce_n, req_ready}), 4'b0111);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 R4 R5 R8 R9: short page, immediate ready status, pass
    run_prog(32'h1234_5678, 3, 4'd1, 4'd1, 0, 8'h40, 0, 0, 20);
    // R6 R8 R9: wider strobes, gapped stream, two not-ready reads, program failure
    run_prog(32'hA1B2_C3D4, 5, 4'd3, 4'd2, 2, 8'h41, 1, 0, 30);
    // R1: zero and oversize counts
    run_prog(32'h0000_0001, 0, 4'd1, 4'd1, 0, 8'h40, 0, 0, 20);
    run_prog(32'h0000_0002, 529, 4'd1, 4'd1, 0, 8'h40, 0, 0, 20);
    // R4: full 528-byte page; cfg 0 treated as 1 (R6)
    run_prog(32'hFFEE_0010, 528, 4'd0, 4'd0, 1, 8'h40, 0, 0, 40);
    // R10: ready/busy never returns
    cfg_busy_limit = 16'd60;
    run_prog(32'h0BAD_CAFE, 2, 4'd2, 4'd1, 0, 8'h40, 0, 1, 20);
    cfg_busy_limit = 16'd1000;
    // R9: pass again after a timeout
    run_prog(32'h7777_0000, 4, 4'd2, 4'd3, 0, 8'h40, 1, 0, 15);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule